// File: doc/BRIEF.md
# Pipelined SPI Register Slave

This block is a slave on a four-wire serial bus that moves 16-bit frames in both directions at once. The host sends a command in one frame and collects the answer in the next: every reply the block shifts out belongs to the frame before it. Through this command stream the host reads three sampled inputs (angle, magnitude and a diagnostic word) and a 14-bit zero-position register. The host writes the zero-position register in two halves.

Each frame carries an even-parity bit. The block checks that bit and counts the serial clocks in every frame. Faults are gathered in a three-bit error register, and every reply exposes them through a sticky flag. A read of the error address returns the fault bits and then empties the register. The serial lines are brought into the system clock domain through flop synchronizers, and all edge detection runs there.

The command decoder has two states. `ST_CMD` expects a command frame. A valid write command that targets a zero-position address moves it to `ST_WDATA`. `ST_WDATA` expects the data frame, and any completed frame returns it to `ST_CMD`: a good data frame, a data frame with bit 14 set, a parity fault or a framing fault. Every other frame leaves the decoder in `ST_CMD`. The frame shifter is idle while chip select is high and shifts while it is low.

Top module: `spi_reg_slave`

## Requirements
- R1: A command frame holds even parity in bit 15, the access kind in bit 14 (1 = read, 0 = write) and the target address in bits 13:0.
- R2: A reply frame holds data in bits 13:0 and the error flag in bit 14. The flag is 1 whenever any error bit is set. Bit 15 makes the count of ones across all 16 bits even.
- R3: The reply to a frame is shifted out during the following frame. The first frame after reset returns 0x0000.
- R4: A write is a command frame followed by a data frame. The data frame returns the old content of the addressed half, and the frame after it returns the new content. If bit 14 of the data frame is 1, the data frame sets the invalid-command bit and leaves the register unchanged.
- R5: MOSI is taken on the falling SCK edge and MISO advances on the rising edge, most significant bit first. MISO is low while CSn is high.
- R6: A frame that does not have exactly 16 SCK clocks sets error bit 0. Its content is discarded, its reply carries zero data, and the decoder returns to `ST_CMD`, which aborts a pending write.
- R7: A frame with odd parity sets error bit 2. Its content is discarded and its reply carries zero data.
- R8: Error bits (2 parity, 1 invalid command, 0 framing) stay set until the host reads address 0x0001. That read returns the error bits in data bits 2:0 with the flag, and then clears them, so the next reply has the flag at 0.
- R9: The all-zero frame (a write to address 0) is a no-operation whose reply is 0x0000 when no error is pending. A read of address 0 also returns zero data.
- R10: A read of 0x3FFF returns the angle input, 0x3FFE the magnitude input and 0x3FFD the diagnostic input. Address 0x0016 maps zero-position bits 13:6 to data bits 7:0. Address 0x0017 maps zero-position bits 5:0 to data bits 5:0. The register resets to 0 and drives `zero_pos_o`.
- R11: A read of an unmapped address, or a write to any address other than 0, 0x0016 and 0x0017, sets error bit 1, returns zero data and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| angle_i | input | 14 | Angle value offered for reading |
| magnitude_i | input | 14 | Magnitude value offered for reading |
| diag_i | input | 14 | Diagnostic and gain word offered for reading |
| zero_pos_o | output | 14 | Current zero-position register |

## Verification
The assertions assume that SCK idles low whenever CSn changes. They also assume that every SCK phase, and the CSn high time between frames, lasts several system clocks, so that the synchronized edges never merge and each reply is loaded before the next frame starts. The stimulus holds each SCK phase for 200 ns and keeps CSn high for 400 ns at a 10 ns system clock. It changes MOSI only on rising SCK edges and samples MISO just before each falling edge. The bench includes frames with 15 and 17 clocks, a frame with bad parity, and a write whose data frame is cut short. These keep the timing legal while still producing the frame faults.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
    localparam int FRAME_W = 16;
    localparam int DATA_W  = 14;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam int ERR_W   = 3;
    localparam int ZP_HI_W = 8;
    localparam int ZP_LO_W = DATA_W - ZP_HI_W;

    localparam int ERR_FRAME = 0;
    localparam int ERR_CMD   = 1;
    localparam int ERR_PAR   = 2;

    localparam logic [DATA_W-1:0] ADR_NOP    = 14'h0000;
    localparam logic [DATA_W-1:0] ADR_ERRCLR = 14'h0001;
    localparam logic [DATA_W-1:0] ADR_ZP_HI  = 14'h0016;
    localparam logic [DATA_W-1:0] ADR_ZP_LO  = 14'h0017;
    localparam logic [DATA_W-1:0] ADR_DIAG   = 14'h3FFD;
    localparam logic [DATA_W-1:0] ADR_MAG    = 14'h3FFE;
    localparam logic [DATA_W-1:0] ADR_ANG    = 14'h3FFF;

    typedef enum logic {ST_CMD, ST_WDATA} core_state_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
    import spi_reg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_s,
    input  logic               cs_s,
    input  logic               mosi_s,
    input  logic [FRAME_W-1:0] tx_word,
    output logic               miso,
    output logic               frame_done,
    output logic [FRAME_W-1:0] rx_word,
    output logic               bits_ok
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    logic               sck_q, cs_q;
    logic               sck_fall, sck_rise, cs_rise;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] rx_sh, tx_sh;

    assign sck_fall = sck_q & ~sck_s;
    assign sck_rise = ~sck_q & sck_s;
    assign cs_rise  = ~cs_q & cs_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q      <= 1'b0;
            cs_q       <= 1'b1;
            cnt        <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            frame_done <= 1'b0;
            rx_word    <= '0;
            bits_ok    <= 1'b0;
        end else begin
            sck_q      <= sck_s;
            cs_q       <= cs_s;
            frame_done <= cs_rise;
            if (cs_rise) begin
                rx_word <= rx_sh;
                bits_ok <= (cnt == CNT_FULL);
            end
            if (cs_s) begin
                // idle: hold the pending reply ready for the next frame
                cnt   <= '0;
                tx_sh <= tx_word;
            end else begin
                if (sck_fall) begin
                    rx_sh <= {rx_sh[FRAME_W-2:0], mosi_s};
                    if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
                end
                if (sck_rise && cnt != '0)
                    tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
            end
        end
    end

    assign miso = ~cs_s & tx_sh[FRAME_W-1];

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_OVER); // R6
endmodule

// File: rtl/spi_reg_core.sv
module spi_reg_core
    import spi_reg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_done,
    input  logic [FRAME_W-1:0] rx_word,
    input  logic               bits_ok,
    input  logic [DATA_W-1:0]  angle_i,
    input  logic [DATA_W-1:0]  magnitude_i,
    input  logic [DATA_W-1:0]  diag_i,
    output logic [FRAME_W-1:0] tx_word,
    output logic [DATA_W-1:0]  zero_pos
);
    core_state_e        state_q, state_d;
    logic               sel_hi_q, sel_hi_d;
    logic [ERR_W-1:0]   err_q, err_set;
    logic               clr_err, wr_en;
    logic [DATA_W-1:0]  reply_data, data_out, wr_val, addr;
    logic               par_ok, is_rd, flag_out;
    logic [FRAME_W-1:0] reply_word;

    function automatic logic [DATA_W-1:0] zp_view(input logic [DATA_W-1:0] zp,
                                                  input logic hi);
        return hi ? DATA_W'(zp[DATA_W-1:ZP_LO_W]) : DATA_W'(zp[ZP_LO_W-1:0]);
    endfunction

    assign par_ok = ~(^rx_word);
    assign is_rd  = rx_word[FRAME_W-2];
    assign addr   = rx_word[DATA_W-1:0];
    assign wr_val = sel_hi_q ? {rx_word[ZP_HI_W-1:0], zero_pos[ZP_LO_W-1:0]}
                             : {zero_pos[DATA_W-1:ZP_LO_W], rx_word[ZP_LO_W-1:0]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_CMD;
            sel_hi_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            sel_hi_q <= sel_hi_d;
        end
    end

    // frame decode and outputs
    always_comb begin
        state_d    = state_q;
        sel_hi_d   = sel_hi_q;
        err_set    = '0;
        clr_err    = 1'b0;
        wr_en      = 1'b0;
        reply_data = '0;
        if (frame_done) begin
            if (!bits_ok) begin
                err_set[ERR_FRAME] = 1'b1;
                state_d = ST_CMD;
            end else if (!par_ok) begin
                err_set[ERR_PAR] = 1'b1;
                state_d = ST_CMD;
            end else begin
                unique case (state_q)
                    ST_CMD: begin
                        if (is_rd) begin
                            case (addr)
                                ADR_NOP:    reply_data = '0;
                                ADR_ERRCLR: clr_err = 1'b1;
                                ADR_ZP_HI:  reply_data = zp_view(zero_pos, 1'b1);
                                ADR_ZP_LO:  reply_data = zp_view(zero_pos, 1'b0);
                                ADR_DIAG:   reply_data = diag_i;
                                ADR_MAG:    reply_data = magnitude_i;
                                ADR_ANG:    reply_data = angle_i;
                                default:    err_set[ERR_CMD] = 1'b1;
                            endcase
                        end else begin
                            case (addr)
                                ADR_NOP: reply_data = '0;
                                ADR_ZP_HI: begin
                                    state_d    = ST_WDATA;
                                    sel_hi_d   = 1'b1;
                                    reply_data = zp_view(zero_pos, 1'b1);
                                end
                                ADR_ZP_LO: begin
                                    state_d    = ST_WDATA;
                                    sel_hi_d   = 1'b0;
                                    reply_data = zp_view(zero_pos, 1'b0);
                                end
                                default: err_set[ERR_CMD] = 1'b1;
                            endcase
                        end
                    end
                    ST_WDATA: begin
                        state_d = ST_CMD;
                        if (rx_word[FRAME_W-2]) begin
                            err_set[ERR_CMD] = 1'b1;
                        end else begin
                            wr_en      = 1'b1;
                            reply_data = zp_view(wr_val, sel_hi_q);
                        end
                    end
                    default: state_d = ST_CMD;
                endcase
            end
        end
    end

    assign flag_out   = clr_err ? (|err_q) : (|(err_q | err_set));
    assign data_out   = clr_err ? DATA_W'(err_q) : reply_data;
    assign reply_word = {^{flag_out, data_out}, flag_out, data_out};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q    <= '0;
            zero_pos <= '0;
            tx_word  <= '0;
        end else begin
            err_q <= clr_err ? '0 : (err_q | err_set);
            if (wr_en)      zero_pos <= wr_val;
            if (frame_done) tx_word  <= reply_word;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_q && !clr_err) |=> |err_q); // R8
    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err |=> (err_q == '0)); // R8
    AST_ZP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(zero_pos)); // R4
    AST_REPLY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !(^tx_word)); // R2
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(tx_word)); // R3
    AST_FRAME_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !bits_ok) |=> (state_q == ST_CMD && err_q[ERR_FRAME])); // R6
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_reg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [DATA_W-1:0] angle_i,
    input  logic [DATA_W-1:0] magnitude_i,
    input  logic [DATA_W-1:0] diag_i,
    output logic [DATA_W-1:0] zero_pos_o
);
    logic [2:0]         line_s;
    logic               frame_done, bits_ok;
    logic [FRAME_W-1:0] rx_word, tx_word;

    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_mosi, spi_sck, spi_cs_n}),
        .q     (line_s)
    );

    spi_frame_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_s      (line_s[1]),
        .cs_s       (line_s[0]),
        .mosi_s     (line_s[2]),
        .tx_word    (tx_word),
        .miso       (spi_miso),
        .frame_done (frame_done),
        .rx_word    (rx_word),
        .bits_ok    (bits_ok)
    );

    spi_reg_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_done  (frame_done),
        .rx_word     (rx_word),
        .bits_ok     (bits_ok),
        .angle_i     (angle_i),
        .magnitude_i (magnitude_i),
        .diag_i      (diag_i),
        .tx_word     (tx_word),
        .zero_pos    (zero_pos_o)
    );
endmodule

// File: tb/tb_spi_reg_slave.sv
module tb_spi_reg_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic        miso;
    logic [13:0] ang = 14'h1A5C, mag = 14'h0F0F, diag = 14'h0180;
    logic [13:0] zp_o;

    int n_chk = 0, n_fail = 0, hi_cnt = 0;
    bit done = 0;

    // behavioural reference state
    logic [2:0]  m_err = '0;
    logic [13:0] m_zp = '0;
    logic        m_wd = 1'b0, m_whi = 1'b0;
    logic [15:0] m_pending = '0;

    always #5 clk = ~clk;

    spi_reg_slave dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso), .angle_i(ang),
        .magnitude_i(mag), .diag_i(diag), .zero_pos_o(zp_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // R5: MISO low on every clock while the frame select is settled high
    always @(negedge clk) begin
        if (rst_n && cs_n) hi_cnt++;
        else hi_cnt = 0;
        if (hi_cnt >= 4) check("R5 idle", {15'b0, miso}, 16'h0000);
    end

    function automatic logic [15:0] mkc(input logic rw, input logic [13:0] a);
        return {^{rw, a}, rw, a};
    endfunction

    task automatic model_step(input logic [15:0] w, input int n);
        logic [13:0] d;
        logic [2:0]  e0;
        logic        f, clrf;
        d = '0; e0 = m_err; clrf = 1'b0;
        if (n != 16) begin
            m_err[0] = 1'b1; m_wd = 1'b0;
        end else if (^w) begin
            m_err[2] = 1'b1; m_wd = 1'b0;
        end else if (m_wd) begin
            m_wd = 1'b0;
            if (w[14]) m_err[1] = 1'b1;
            else if (m_whi) begin m_zp[13:6] = w[7:0]; d = {6'b0, w[7:0]}; end
            else begin m_zp[5:0] = w[5:0]; d = {8'b0, w[5:0]}; end
        end else if (w[14]) begin
            case (w[13:0])
                14'h0000: d = '0;
                14'h0001: clrf = 1'b1;
                14'h0016: d = {6'b0, m_zp[13:6]};
                14'h0017: d = {8'b0, m_zp[5:0]};
                14'h3FFD: d = diag;
                14'h3FFE: d = mag;
                14'h3FFF: d = ang;
                default:  m_err[1] = 1'b1;
            endcase
        end else begin
            case (w[13:0])
                14'h0000: d = '0;
                14'h0016: begin m_wd = 1'b1; m_whi = 1'b1; d = {6'b0, m_zp[13:6]}; end
                14'h0017: begin m_wd = 1'b1; m_whi = 1'b0; d = {8'b0, m_zp[5:0]}; end
                default:  m_err[1] = 1'b1;
            endcase
        end
        if (clrf) begin
            d = {11'b0, e0}; f = |e0; m_err = '0;
        end else begin
            f = |m_err;
        end
        m_pending = {^{f, d}, f, d};
    endtask

    task automatic xfer(input logic [15:0] w, input int n, output logic [15:0] got);
        got = '0;
        cs_n = 1'b0;
        #200;
        for (int i = 0; i < n; i++) begin
            sck = 1'b1;
            mosi = (i < 16) ? w[15-i] : 1'b0;
            #200;
            if (i < 16) got = {got[14:0], miso};
            sck = 1'b0;
            #200;
        end
        #200;
        cs_n = 1'b1;
        #400;
    endtask

    task automatic frame(input logic [15:0] w, input int n, input string req);
        logic [15:0] got;
        xfer(w, n, got);
        if (n >= 16) check(req, got, m_pending);
        model_step(w, n);
    endtask

    initial begin
        #50 rst_n = 1'b1;
        @(negedge clk);
        #100;
        check("R3 reset miso", {15'b0, miso}, 16'h0000);
        check("R10 reset zero_pos", {2'b0, zp_o}, 16'h0000);

        frame(16'h0000, 16, "R3 first reply");
        frame(mkc(1'b1, 14'h3FFF), 16, "R9 nop reply");
        frame(mkc(1'b1, 14'h3FFE), 16, "R10 angle R1");
        frame(mkc(1'b1, 14'h3FFD), 16, "R10 magnitude");
        frame(mkc(1'b1, 14'h0000), 16, "R10 diag");
        frame(mkc(1'b0, 14'h0016), 16, "R9 read addr0");
        frame(mkc(1'b0, 14'h00A5), 16, "R4 old hi");
        frame(mkc(1'b0, 14'h0017), 16, "R4 new hi");
        frame(mkc(1'b0, 14'h002B), 16, "R4 old lo");
        frame(mkc(1'b1, 14'h0016), 16, "R4 new lo");
        frame(mkc(1'b1, 14'h0017), 16, "R10 read hi");
        frame(16'h0000, 16, "R10 read lo");
        check("R10 zero_pos port", {2'b0, zp_o}, {2'b0, m_zp});

        frame(mkc(1'b0, 14'h0016), 16, "R3 nop");
        frame(mkc(1'b1, 14'h0011), 16, "R4 old hi bad data");
        frame(16'h0000, 16, "R4 bad data flag");
        check("R4 bad data no write", {2'b0, zp_o}, {2'b0, m_zp});
        frame(mkc(1'b1, 14'h0001), 16, "R11 flag pending");
        frame(16'h0000, 16, "R8 error content");
        frame(16'h0000, 16, "R8 flag cleared");

        frame(mkc(1'b1, 14'h3FFF) ^ 16'h8000, 16, "R9 nop before parity");
        frame(mkc(1'b1, 14'h0001), 16, "R7 parity reply");
        frame(16'h0000, 16, "R7 parity bit");

        frame(mkc(1'b1, 14'h3FFF), 15, "R6 short");
        frame(mkc(1'b1, 14'h3FFF), 17, "R6 short reply");
        frame(mkc(1'b1, 14'h0001), 16, "R6 long reply");
        frame(16'h0000, 16, "R6 framing bit");

        frame(mkc(1'b1, 14'h0100), 16, "R11 prior");
        frame(mkc(1'b0, 14'h3FFF), 16, "R11 unmapped read");
        frame(mkc(1'b1, 14'h0001), 16, "R11 readonly write");
        frame(16'h0000, 16, "R11 invalid bit");
        check("R11 zero_pos kept", {2'b0, zp_o}, {2'b0, m_zp});

        frame(mkc(1'b0, 14'h0017), 16, "R3 before abort");
        frame(mkc(1'b0, 14'h0033), 15, "R6 aborted data");
        frame(16'h0000, 16, "R6 abort flag");
        frame(mkc(1'b1, 14'h0017), 16, "R6 nop not data");
        frame(mkc(1'b1, 14'h0001), 16, "R6 lo kept");
        frame(16'h0000, 16, "R8 flush");
        check("R6 zero_pos after abort", {2'b0, zp_o}, {2'b0, m_zp});

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule